// File: doc/BRIEF.md
# Position Word Latch and Host Bus Port

This block sits between a 16-bit position counter and a host data bus that is either eight or sixteen bits wide. A holding register follows the counter on every clock. A host that wants a consistent reading freezes the register with an active-low hold input, reads it, and then releases it. The register does not load while the counter reports that it is in the middle of an update. This keeps a half-changed word from being captured.

On the way out, the held word can be inverted bit for bit through an active-low invert input. The word is then steered onto sixteen output lines. The low eight lines carry the upper or the lower byte, as a byte-select input picks. The upper eight lines always carry the lower byte.

An 8-bit host reads the two halves from the low lines by toggling the byte select. A 16-bit host keeps the select high and sees the upper byte on the low lines and the lower byte on the upper lines. The words are in natural binary.

Pad tri-stating is modelled by a drive-enable output. When the drive-enable is low, the data lines are held at zero.

Top module: `pos_bus_port`

## Requirements
- R1: While reset is asserted, the holding register is zero, `data_oe_o` is 0 and `data_o` is all zeros.
- R2: At a clock edge where `hold_n_i` is 1 and `cnt_busy_i` is 0, the holding register takes the value of `cnt_i`. The new value is visible on the outputs before the next edge.
- R3: At a clock edge where `hold_n_i` is 0, the holding register keeps its value whatever `cnt_i` does.
- R4: At a clock edge where `cnt_busy_i` is 1, the holding register keeps its value.
- R5: When `bus_en_n_i` is 1, `data_oe_o` is 0 and `data_o` is all zeros. When `bus_en_n_i` is 0 outside reset, and at least one clock edge has passed since reset was released, `data_oe_o` is 1.
- R6: While the bus is driven, `data_o[7:0]` carries bits 15:8 of the presented word when `hi_sel_i` is 1. It carries bits 7:0 of the presented word when `hi_sel_i` is 0.
- R7: While the bus is driven, `data_o[15:8]` carries bits 7:0 of the presented word for either value of `hi_sel_i`.
- R8: The presented word is the bitwise inverse of the holding register when `invert_n_i` is 0. It equals the holding register when `invert_n_i` is 1.
- R9: At the first clock edge after `hold_n_i` returns to 1, with `cnt_busy_i` at 0, the holding register takes the value `cnt_i` has at that edge, not any value from the frozen period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Position counter value |
| cnt_busy_i | input | 1 | Counter is mid-update; blocks loading |
| hold_n_i | input | 1 | Active-low freeze of the holding register |
| bus_en_n_i | input | 1 | Active-low bus drive enable |
| hi_sel_i | input | 1 | 1: upper byte on low lines, 0: lower byte on low lines |
| invert_n_i | input | 1 | Active-low bitwise inversion of the output word |
| data_o | output | 16 | Data lines (zero when not driven) |
| data_oe_o | output | 1 | Data lines driven |

## Verification
The case hardest to reach from the ports is a freeze that overlaps counter activity. The counter changes while held, and the hold is released on the same cycle that the busy flag drops or rises. A stale or premature load would only show up there.

The stimulus produces this with directed sequences that change `cnt_i` on every frozen cycle and then release the hold with busy both high and low. A long random phase then flips hold, busy, select, invert and enable at independent rates. The register model is updated only when the load condition is met.

// File: rtl/pos_bus_pkg.sv
package pos_bus_pkg;
  localparam int unsigned DEF_WORD_W = 16;
  localparam int unsigned DEF_LANE_W = 8;

  typedef enum logic {
    PICK_LOW  = 1'b0,
    PICK_HIGH = 1'b1
  } lane_pick_e;
endpackage

// File: rtl/pos_capture.sv
module pos_capture #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cnt_i,
  input  logic              busy_i,
  input  logic              hold_n_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);
  logic [WORD_W-1:0] word_q;

  function automatic logic load_allowed(input logic hold_n, input logic busy);
    return hold_n & ~busy;
  endfunction

  assign load_o = load_allowed(hold_n_i, busy_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (load_o) word_q <= cnt_i;
  end

  assign word_o = word_q;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_n_i && !busy_i) |=> (word_o == $past(cnt_i)));
  assert_hold_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n_i |=> $stable(word_o));
  assert_busy_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(word_o));
  assert_release_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hold_n_i) && !busy_i) |=> (word_o == $past(cnt_i)));
endmodule

// File: rtl/pos_format.sv
module pos_format #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              invert_n_i,
  input  logic              hi_sel_i,
  output logic [WORD_W-1:0] bus_o
);
  import pos_bus_pkg::*;
  localparam int unsigned NUM_LANES = WORD_W / LANE_W;

  logic [WORD_W-1:0] shown;
  lane_pick_e        pick;

  function automatic logic [WORD_W-1:0] apply_polarity(input logic [WORD_W-1:0] w,
                                                       input logic inv_n);
    return inv_n ? w : ~w;
  endfunction

  function automatic logic [LANE_W-1:0] lane_of(input logic [WORD_W-1:0] w,
                                                input int unsigned idx);
    return w[idx*LANE_W +: LANE_W];
  endfunction

  assign shown = apply_polarity(word_i, invert_n_i);
  assign pick  = hi_sel_i ? PICK_HIGH : PICK_LOW;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    if (i == 0) begin : g_steer
      assign bus_o[LANE_W-1:0] = (pick == PICK_HIGH) ? lane_of(shown, NUM_LANES-1)
                                                     : lane_of(shown, 0);
    end else begin : g_fixed
      assign bus_o[i*LANE_W +: LANE_W] = lane_of(shown, i-1);
    end
  end

  assert_invert_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(word_i) && $stable(hi_sel_i) && (invert_n_i != $past(invert_n_i)))
      |-> (bus_o == ~$past(bus_o)));
endmodule

// File: rtl/pos_drive.sv
module pos_drive #(
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_n_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic [BUS_W-1:0] data_o,
  output logic             oe_o
);
  logic run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  assign oe_o   = run_q & ~en_n_i;
  assign data_o = oe_o ? bus_i : '0;

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!oe_o && (data_o == '0));
    end
  end

  assert_float_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_i |-> (!oe_o && (data_o == '0)));
  assert_drive_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n_i && $past(rst_n)) |=> (oe_o || en_n_i));
endmodule

// File: rtl/pos_bus_port.sv
module pos_bus_port #(
  parameter int unsigned WORD_W = pos_bus_pkg::DEF_WORD_W,
  parameter int unsigned LANE_W = pos_bus_pkg::DEF_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] cnt_i,
  input  logic              cnt_busy_i,
  input  logic              hold_n_i,
  input  logic              bus_en_n_i,
  input  logic              hi_sel_i,
  input  logic              invert_n_i,
  output logic [WORD_W-1:0] data_o,
  output logic              data_oe_o
);
  logic [WORD_W-1:0] held_word;
  logic              load_evt;
  logic [WORD_W-1:0] steered;

  pos_capture #(.WORD_W(WORD_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .busy_i(cnt_busy_i),
    .hold_n_i(hold_n_i), .word_o(held_word), .load_o(load_evt)
  );

  pos_format #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_format (
    .clk(clk), .rst_n(rst_n), .word_i(held_word), .invert_n_i(invert_n_i),
    .hi_sel_i(hi_sel_i), .bus_o(steered)
  );

  pos_drive #(.BUS_W(WORD_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .en_n_i(bus_en_n_i), .bus_i(steered),
    .data_o(data_o), .oe_o(data_oe_o)
  );

  assert_low_lane_ls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o && !hi_sel_i) |-> (data_o[LANE_W-1:0] == data_o[LANE_W +: LANE_W]));
  assert_upper_lane_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe_o && $past(data_oe_o) && !load_evt && $stable(held_word) && $stable(invert_n_i)
      && $past(!load_evt)) |-> $stable(data_o[LANE_W +: LANE_W]));
endmodule

// File: tb/pos_bus_port_bench.sv
module pos_bus_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = '0;
  logic        cnt_busy_i = 1'b0;
  logic        hold_n_i = 1'b1;
  logic        bus_en_n_i = 1'b1;
  logic        hi_sel_i = 1'b0;
  logic        invert_n_i = 1'b1;
  logic [15:0] data_o;
  logic        data_oe_o;

  int          n_tests = 0;
  int          n_fail = 0;
  logic [15:0] model_reg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pos_bus_port u_pos_bus_port (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cnt_busy_i(cnt_busy_i),
    .hold_n_i(hold_n_i), .bus_en_n_i(bus_en_n_i), .hi_sel_i(hi_sel_i),
    .invert_n_i(invert_n_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  function automatic logic [15:0] exp_bus(input logic [15:0] r, input logic inv_n,
                                          input logic sel, input logic en_n);
    logic [15:0] w;
    logic [7:0]  lo;
    if (en_n) return 16'h0000;
    w  = r ^ {16{~inv_n}};
    lo = sel ? 8'(w >> 8) : 8'(w & 16'h00FF);
    return {8'(w & 16'h00FF), lo};
  endfunction

  task automatic check(input string tag);
    logic [15:0] e;
    e = exp_bus(model_reg, invert_n_i, hi_sel_i, bus_en_n_i);
    n_tests++;
    if (data_oe_o !== ~bus_en_n_i || data_o !== e) begin
      n_fail++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", tag,
               data_oe_o, data_o, ~bus_en_n_i, e);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    if (hold_n_i && !cnt_busy_i) model_reg = cnt_i;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #(CLK_PERIOD*2);
    n_tests++;
    if (data_oe_o !== 1'b0 || data_o !== 16'h0000) begin
      n_fail++;
      $display("FAIL R1: oe=%b data=%h expected oe=0 data=0000", data_oe_o, data_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    hold_n_i = 1'b0;
    bus_en_n_i = 1'b0;
    step("R1 register zero after reset");
    invert_n_i = 1'b0;
    #1 check("R8 inverted zero");
    // R2 R6 R7 basic load and steering
    invert_n_i = 1'b1; hold_n_i = 1'b1; cnt_i = 16'hA55A; hi_sel_i = 1'b1;
    step("R2 R6 load, high byte on low lines");
    hi_sel_i = 1'b0;
    #1 check("R6 R7 low byte on both lanes");
    // R3 freeze while counter moves
    hold_n_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      cnt_i = 16'h1111 * 16'(k + 1);
      hi_sel_i = k[0];
      step("R3 frozen during counter motion");
    end
    // R9 release with busy high then low
    cnt_i = 16'h0F0F; hold_n_i = 1'b1; cnt_busy_i = 1'b1;
    step("R4 busy blocks load on release");
    cnt_busy_i = 1'b0; cnt_i = 16'hBEEF;
    step("R9 release captures current value");
    // R4 busy mid-run
    cnt_busy_i = 1'b1; cnt_i = 16'h1234;
    step("R4 busy holds register");
    cnt_busy_i = 1'b0;
    step("R2 load after busy");
    // R5 enable off
    bus_en_n_i = 1'b1;
    #1 check("R5 lines released");
    bus_en_n_i = 1'b0; invert_n_i = 1'b0; cnt_i = 16'hFFFF;
    step("R8 all ones inverted");
    // random phase
    for (int k = 0; k < 2000; k++) begin
      cnt_i      = 16'($urandom);
      cnt_busy_i = ($urandom % 4) == 0;
      hold_n_i   = ($urandom % 3) != 0;
      bus_en_n_i = ($urandom % 5) == 0;
      hi_sel_i   = 1'($urandom);
      invert_n_i = 1'($urandom);
      step("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule